// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects 64 interrupt inputs and turns them into eight request lines: a normal interrupt line, a fast interrupt line and six secondary lines. Each source has a control byte. The byte holds an enable bit and a trigger mode, which is active-high level, rising edge or falling edge. It also holds a 3-bit destination that picks one of the eight lines. The source inputs are asynchronous. They pass through a two-flop synchronizer, and edge detection compares each synchronized value with the value from the previous cycle.

An edge-triggered source latches a pending bit. The bit stays set until software writes a one to it in the status words. A level source is pending for as long as its synchronized input is high. A winner register reports the number of the chosen enabled source routed to the normal line. With rotation off, the chosen source is the lowest-numbered one. With rotation on, the search starts one past the last source granted, and the grant pointer moves each time the winner register is read while a request is present. When nothing is active the winner register reads 63, so software tells a real source 63 apart by checking status bit 31 of the upper status word.

Software reaches the block through a simple register bus with word addresses and per-byte write enables. Read data is registered and appears one cycle after the read strobe.

Top module: `rotirq_ctrl`

## Requirements
- R1: After reset every control byte reads 0, all eight output lines are low, and the winner register (offset 0x00) reads 63.
- R2: The control byte of source n sits at byte address 0x40+n: word 0x40+4*(n/4), byte lane n%4. A write changes only the lanes whose byte enable is set.
- R3: With control bits 5 and 6 both 0, the source is level-sensitive. Its status bit equals its synchronized input, and while the enable (bit 3) is 1 and the input is high it drives its destination line.
- R4: Bit 5 set latches pending on a rising input edge, and bit 6 set latches pending on a falling edge. Status for sources 0-31 is at 0x80 and for sources 32-63 at 0x84, with source n at bit n%32.
- R5: Writing 1 to a status bit of an edge source clears its pending bit. Writing 0 leaves it unchanged.
- R6: A source whose enable bit is 0 drives no output line and never wins, but its latched edge pending bit is kept.
- R7: Control bits 2:0 select the destination: 0 drives irq_o, 1 drives fiq_o, and 2 to 7 drive sec_o[0] to sec_o[5]. The output lines are registered.
- R8: With rotation off, the winner register returns, in bits 5:0, the lowest-numbered active source routed to irq_o. It returns 63 when there is none.
- R9: Writing bit 6 of offset 0x20 turns rotation on, and bits 5:0 of that write load the grant pointer. With rotation on, the search starts at pointer+1 and wraps. Each read of 0x00 while a request is active loads the pointer with the winner. Offset 0x20 reads back the rotation bit in bit 6 and the pointer in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous interrupt source inputs |
| bus_addr | input | 8 | Register byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |
| sec_o | output | 6 | Secondary destination lines |

## Verification
Fixed priority is tried with these input patterns:
- no input, which separates idle from a genuine source 63 through status bit 31;
- a single source;
- sources split across the two status words, so the lower word must win;
- source 63 alone and source 63 together with source 0.

Edge sources are pulsed in both directions, so a rising-only source that latches on a fall, or the reverse, shows up. They are then written with zeros and with ones, which separates a real write-1-to-clear from a plain overwrite. Rotation is tried with two level sources held high, so the winners 4, 7, 4 differ from the fixed answer 4, 4, 4. Routing uses a fast-line source and a secondary-line source side by side, to catch a destination decode that is wrong by one.

// File: rtl/rotirq_pkg.sv
package rotirq_pkg;
  localparam int OFF_WIN  = 'h00;
  localparam int OFF_IPRI = 'h20;
  localparam int OFF_CTL  = 'h40;
  localparam int OFF_STA  = 'h80;
  localparam int ROT_BIT  = 6;

  typedef struct packed {
    logic       rsv7;
    logic       fall;
    logic       rise;
    logic       rsv4;
    logic       en;
    logic [2:0] dest;
  } ctl_t;
endpackage

// File: rtl/rotirq_edge.sv
module rotirq_edge #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] lvl,
  output logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] fall
);
  logic [NUM_SRC-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= src_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/rotirq_router.sv
module rotirq_router #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_DEST = 8,
  localparam int DST_W   = $clog2(NUM_DEST)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] act,
  input  logic [DST_W-1:0]   dest [NUM_SRC],
  output logic [NUM_SRC-1:0] irq_req,
  output logic [NUM_DEST-1:0] lines
);
  logic [NUM_SRC-1:0] match [NUM_DEST];

  always_comb begin
    for (int d = 0; d < NUM_DEST; d++)
      for (int n = 0; n < NUM_SRC; n++)
        match[d][n] = act[n] && (dest[n] == DST_W'(d));
  end

  assign irq_req = match[0];

  always_ff @(posedge clk) begin
    if (rst) lines <= '0;
    else
      for (int d = 0; d < NUM_DEST; d++) lines[d] <= |match[d];
  end
endmodule

// File: rtl/rotirq_arb.sv
module rotirq_arb #(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               rot_en,
  input  logic               grant,
  input  logic               ptr_wr,
  input  logic [SRC_W-1:0]   ptr_wdata,
  output logic [SRC_W-1:0]   win,
  output logic [SRC_W-1:0]   ptr
);
  logic [SRC_W-1:0] start, idx;
  logic             found;

  always_comb begin
    start = rot_en ? ptr + SRC_W'(1) : '0;
    win   = SRC_W'(NUM_SRC - 1);
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      idx = start + SRC_W'(i);
      if (!found && req[idx]) begin
        win   = idx;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ptr_wr) ptr <= ptr_wdata;
    else if (grant && (|req)) ptr <= win;
  end

  p_win_req_r8: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> req[win]);
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(|req) |-> (win == SRC_W'(NUM_SRC - 1)));
  p_ptr_move_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(grant || ptr_wr));
endmodule

// File: rtl/rotirq_ctrl.sv
module rotirq_ctrl
  import rotirq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8,
  parameter int NUM_SEC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [NUM_SEC-1:0] sec_o
);
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int CW       = NUM_SRC / 4;
  localparam int SW       = NUM_SRC / 32;
  localparam int NUM_DEST = 2 + NUM_SEC;
  localparam int DST_W    = $clog2(NUM_DEST);

  ctl_t               ctl [NUM_SRC];
  logic [DST_W-1:0]   dest_v [NUM_SRC];
  logic [NUM_SRC-1:0] lvl, rise, fall, pend, stat, act, irq_req;
  logic [NUM_DEST-1:0] lines;
  logic [SRC_W-1:0]   win, ptr;
  logic               rot_en;
  logic [31:0]        rd_nx;

  wire ipri_wr = bus_wr && (bus_addr == ADDR_W'(OFF_IPRI)) && bus_be[0];
  wire grant   = bus_rd && (bus_addr == ADDR_W'(OFF_WIN));

  rotirq_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst(rst), .src_i(src_i), .lvl(lvl), .rise(rise), .fall(fall));

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(OFF_CTL + 4 * (n / 4));
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(OFF_STA + 4 * (n / 32));
    logic is_edge, set_p, clr_p;

    always_ff @(posedge clk) begin
      if (rst) ctl[n] <= '0;
      else if (bus_wr && (bus_addr == CA) && bus_be[n % 4])
        ctl[n] <= bus_wdata[8 * (n % 4) +: 8];
    end

    assign is_edge = ctl[n].rise | ctl[n].fall;
    assign set_p   = (ctl[n].rise & rise[n]) | (ctl[n].fall & fall[n]);
    assign clr_p   = bus_wr && (bus_addr == SA) && bus_be[(n % 32) / 8]
                     && bus_wdata[n % 32];

    always_ff @(posedge clk) begin
      if (rst) pend[n] <= 1'b0;
      else     pend[n] <= (set_p | (pend[n] & ~clr_p)) & is_edge;
    end

    assign stat[n]   = is_edge ? pend[n] : lvl[n];
    assign act[n]    = stat[n] & ctl[n].en;
    assign dest_v[n] = ctl[n].dest;

    p_pend_keep_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[n]) |-> $past(clr_p || !is_edge));
  end

  rotirq_router #(.NUM_SRC(NUM_SRC), .NUM_DEST(NUM_DEST)) u_router (
    .clk(clk), .rst(rst), .act(act), .dest(dest_v),
    .irq_req(irq_req), .lines(lines));

  rotirq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst(rst), .req(irq_req), .rot_en(rot_en), .grant(grant),
    .ptr_wr(ipri_wr), .ptr_wdata(bus_wdata[SRC_W-1:0]), .win(win), .ptr(ptr));

  always_ff @(posedge clk) begin
    if (rst) rot_en <= 1'b0;
    else if (ipri_wr) rot_en <= bus_wdata[ROT_BIT];
  end

  always_comb begin
    rd_nx = '0;
    if (bus_addr == ADDR_W'(OFF_WIN)) rd_nx[SRC_W-1:0] = win;
    if (bus_addr == ADDR_W'(OFF_IPRI)) begin
      rd_nx[ROT_BIT]     = rot_en;
      rd_nx[SRC_W-1:0]   = ptr;
    end
    for (int w = 0; w < SW; w++)
      if (bus_addr == ADDR_W'(OFF_STA + 4 * w)) rd_nx = stat[32 * w +: 32];
    for (int w = 0; w < CW; w++)
      if (bus_addr == ADDR_W'(OFF_CTL + 4 * w))
        for (int j = 0; j < 4; j++) rd_nx[8 * j +: 8] = ctl[4 * w + j];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nx;
  end

  assign irq_o = lines[0];
  assign fiq_o = lines[1];
  assign sec_o = lines[NUM_DEST-1:2];

  p_mask_r6: assert property (@(posedge clk) disable iff (rst)
    !(|act) |=> !irq_o && !fiq_o && (sec_o == '0));
endmodule

// File: tb/rotirq_ctrl_bench.sv
module rotirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  logic [5:0]  sec_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rotirq_ctrl u_rotirq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .sec_o(sec_o));

  localparam int NV = 6;
  localparam logic [63:0] TV_IN [NV] = '{
    64'h0, 64'h20, (64'h1 << 9) | (64'h1 << 40), 64'h1 << 63,
    (64'h1 << 63) | 64'h1, (64'h1 << 47) | (64'h1 << 33)};
  localparam logic [5:0] TV_WIN [NV] = '{6'd63, 6'd5, 6'd9, 6'd63, 6'd0, 6'd33};
  localparam logic TV_IRQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic TV_S31 [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    wt(3);
    rst = 1'b0;
    wt(2);
    // R1 reset state
    rd(8'h40, d); check("R1 ctrl word 0", d, 32'h0);
    rd(8'h7C, d); check("R1 ctrl word 15", d, 32'h0);
    rd(8'h00, d); check("R1 winner idle", d, 32'd63);
    check("R1 lines low", {irq_o, fiq_o, sec_o}, 32'h0);

    // R2 byte lanes
    wr(8'h44, 4'b0100, 32'h11223344);
    rd(8'h44, d); check("R2 single lane", d, 32'h00220000);
    wr(8'h44, 4'b1111, 32'h0);

    // enable all sources, level mode, to IRQ
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4 * w), 4'hF, 32'h08080808);

    // R3 R8 fixed priority vector table
    for (int v = 0; v < NV; v++) begin
      src_i = TV_IN[v];
      wt(5);
      rd(8'h00, d); check($sformatf("R8 winner vec%0d", v), d, {26'h0, TV_WIN[v]});
      check($sformatf("R3 irq vec%0d", v), {31'h0, irq_o}, {31'h0, TV_IRQ[v]});
      rd(8'h84, d); check($sformatf("R4 s31 vec%0d", v), {31'h0, d[31]}, {31'h0, TV_S31[v]});
      rd(8'h80, d); check($sformatf("R3 stat lo vec%0d", v), d, TV_IN[v][31:0]);
    end
    src_i = '0;
    wt(5);

    // R4 rising edge on source 2
    wr(8'h40, 4'b0100, 32'h00280000);
    src_i[2] = 1'b1; wt(5);
    src_i[2] = 1'b0; wt(5);
    rd(8'h80, d); check("R4 rise latched", d, 32'h4);
    check("R4 irq from edge", {31'h0, irq_o}, 32'h1);
    rd(8'h00, d); check("R8 edge winner", d, 32'd2);
    // R5 write zeros
    wr(8'h80, 4'hF, 32'h0);
    rd(8'h80, d); check("R5 zero write keeps", d, 32'h4);
    // R6 mask keeps pending
    wr(8'h40, 4'b0100, 32'h00200000);
    wt(3);
    check("R6 masked irq low", {31'h0, irq_o}, 32'h0);
    rd(8'h00, d); check("R6 masked not winner", d, 32'd63);
    rd(8'h80, d); check("R6 pending kept", d, 32'h4);
    wr(8'h80, 4'hF, 32'h4);
    rd(8'h80, d); check("R5 one write clears", d, 32'h0);

    // R4 falling edge on source 35 (word 0x60 lane 3)
    wr(8'h60, 4'b1000, 32'h48000000);
    src_i[35] = 1'b1; wt(5);
    rd(8'h84, d); check("R4 fall ignores rise", d, 32'h0);
    src_i[35] = 1'b0; wt(5);
    rd(8'h84, d); check("R4 fall latched", d, 32'h8);
    rd(8'h00, d); check("R8 fall winner", d, 32'd35);
    wr(8'h84, 4'b0001, 32'h8);
    rd(8'h84, d); check("R5 clear upper", d, 32'h0);

    // R7 routing: src10 -> FIQ, src11 -> dest4 = sec_o[2]
    wr(8'h48, 4'b1100, 32'h0C090000);
    src_i[10] = 1'b1; src_i[11] = 1'b1; wt(5);
    check("R7 fiq", {31'h0, fiq_o}, 32'h1);
    check("R7 sec", {26'h0, sec_o}, 32'h4);
    check("R7 irq idle", {31'h0, irq_o}, 32'h0);
    src_i = '0; wt(5);
    check("R7 sec clear", {26'h0, sec_o}, 32'h0);

    // R9 rotation with level sources 4 and 7
    wr(8'h20, 4'b0001, 32'h40);
    rd(8'h20, d); check("R9 readback", d, 32'h40);
    src_i[4] = 1'b1; src_i[7] = 1'b1; wt(5);
    rd(8'h00, d); check("R9 rot first", d, 32'd4);
    rd(8'h00, d); check("R9 rot second", d, 32'd7);
    rd(8'h00, d); check("R9 rot wrap", d, 32'd4);
    rd(8'h20, d); check("R9 pointer", d, 32'h44);
    wr(8'h20, 4'b0001, 32'h00);
    rd(8'h00, d); check("R8 fixed again", d, 32'd4);
    rd(8'h00, d); check("R8 fixed repeat", d, 32'd4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule